// File: doc/BRIEF.md
# Translation Region Selector

This block decides which of two translation table bases serves a 64-bit input address, or whether the address is unmapped. Each request carries the address, a size field per region, two tag-ignore enables and a disable flag per region. The block reports one of three outcomes: region 0, region 1, or translation fault. Walking the tables and checking permissions belong to other blocks.

Region 0 owns the low end of the address space, where the top bits are all zero. Region 1 owns the high end, where they are all ones. A size field of `n` means the top `n` address bits must match the region's fill pattern. Address bit 55 picks the tag-ignore enable that applies. When that enable is set, the top byte takes no part in either region test.

Requests enter on a valid/ready port and results leave on a valid/ready port, through a single output register. `in_ready` is high whenever the register is empty or its content is being taken in the same cycle. A result that is offered and not taken stays unchanged until `out_ready` rises. Back-pressure therefore stops the input after one request.

Top module: `xlat_region_sel`

## Requirements
- R1: Address bit 55 picks the tag-ignore enable: `in_tag_ign0` when the bit is 0, `in_tag_ign1` when it is 1.
- R2: When the picked tag-ignore enable is 1, address bits 63..56 are excluded from both region tests. For a size field `n`, the tested bits are `[63-i : 64-n]`, where `i` is 8 if bits are ignored and 0 otherwise. An empty tested range counts as a match.
- R3: With `in_span0` nonzero and every tested bit 0, the outcome is region 0.
- R4: Otherwise, with `in_span1` nonzero and every tested bit 1, the outcome is region 1.
- R5: Otherwise, if `in_span0` is zero, the outcome is region 0.
- R6: Otherwise, if `in_span1` is zero, the outcome is region 1.
- R7: Otherwise, when both size fields are nonzero and neither test matched, the outcome is a translation fault.
- R8: If the region chosen by R3 to R6 has its disable flag (`in_off0` or `in_off1`) set, the outcome is a translation fault instead.
- R9: While `out_valid` is 1, exactly one of `out_sel0`, `out_sel1` and `out_fault` is 1.
- R10: A request accepted on a rising edge (`in_valid` and `in_ready` both 1) has its outcome on the outputs, with `out_valid` set, right after that edge. `in_ready` equals `!out_valid || out_ready`.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and the outcome bits hold their values.
- R12: While `rst_n` is 0, and right after it is released, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_addr | input | 64 | Address to classify |
| in_span0 | input | 6 | Size field of region 0 |
| in_span1 | input | 6 | Size field of region 1 |
| in_tag_ign0 | input | 1 | Top-byte ignore, used when address bit 55 is 0 |
| in_tag_ign1 | input | 1 | Top-byte ignore, used when address bit 55 is 1 |
| in_off0 | input | 1 | Region 0 disabled |
| in_off1 | input | 1 | Region 1 disabled |
| out_valid | output | 1 | Outcome present |
| out_ready | input | 1 | Consumer takes the outcome |
| out_sel0 | output | 1 | Outcome: region 0 |
| out_sel1 | output | 1 | Outcome: region 1 |
| out_fault | output | 1 | Outcome: translation fault |

## Verification
Every outcome is due exactly one rising edge after its request is accepted, and stays in place for as many cycles as `out_ready` is held low. `in_ready` follows `out_ready` with no register in between. The bench keeps a queue of expected outcomes. It pushes an entry on each accepted request and pops one on each taken result, both at the rising edge. It compares `out_valid`, the outcome bits and `in_ready` at the falling edge, so each result is sampled half a cycle after the edge that produced it.

// File: rtl/rsel_pkg.sv
package rsel_pkg;
  // one-hot outcome, bit order {fault, region1, region0}
  typedef enum logic [2:0] {
    PICK_R0    = 3'b001,
    PICK_R1    = 3'b010,
    PICK_FAULT = 3'b100
  } pick_t;
endpackage

// File: rtl/rsel_span_mask.sv
// Marks the address bits that take part in a region test.
module rsel_span_mask #(
  parameter int ADDR_W = 64,
  parameter int SZ_W   = 6,
  parameter int TAG_W  = 8
) (
  input  logic [SZ_W-1:0]   span,
  input  logic              ign,
  output logic [ADDR_W-1:0] mask
);
  logic [31:0] span_w;
  assign span_w = 32'(span);

  for (genvar p = 0; p < ADDR_W; p++) begin : g_bit
    localparam bit IN_TAG = (p >= ADDR_W - TAG_W);
    // bit p is inside the top 'span' bits and not in an ignored tag byte
    assign mask[p] = ((span_w + 32'(p)) >= 32'(ADDR_W)) && !(ign && IN_TAG);
  end
endmodule

// File: rtl/rsel_region_hit.sv
// Tests the masked address bits against the region's fill pattern.
module rsel_region_hit #(
  parameter int ADDR_W    = 64,
  parameter bit WANT_ONES = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] mask,
  output logic              hit
);
  logic [ADDR_W-1:0] kept;
  assign kept = addr & mask;

  if (WANT_ONES) begin : g_ones
    assign hit = (kept == mask);
  end else begin : g_zero
    assign hit = (kept == '0);
  end
endmodule

// File: rtl/rsel_arbiter.sv
// Ordered choice between the two regions, then the disable override.
module rsel_arbiter
  import rsel_pkg::*;
(
  input  logic  live0,
  input  logic  live1,
  input  logic  hit0,
  input  logic  hit1,
  input  logic  off0,
  input  logic  off1,
  output pick_t pick
);
  pick_t cand;

  always_comb begin
    if (live0 && hit0)      cand = PICK_R0;
    else if (live1 && hit1) cand = PICK_R1;
    else if (!live0)        cand = PICK_R0;
    else if (!live1)        cand = PICK_R1;
    else                    cand = PICK_FAULT;

    pick = cand;
    if ((cand == PICK_R0 && off0) || (cand == PICK_R1 && off1)) pick = PICK_FAULT;
  end
endmodule

// File: rtl/rsel_out_reg.sv
// Single-entry output register with valid/ready on both sides.
module rsel_out_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/xlat_region_sel.sv
module xlat_region_sel
  import rsel_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int SZ_W    = 6,
  parameter int TAG_W   = 8,
  parameter int SEL_BIT = 55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [SZ_W-1:0]   in_span0,
  input  logic [SZ_W-1:0]   in_span1,
  input  logic              in_tag_ign0,
  input  logic              in_tag_ign1,
  input  logic              in_off0,
  input  logic              in_off1,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_sel0,
  output logic              out_sel1,
  output logic              out_fault
);
  localparam int NREG  = 2;
  localparam int PICKW = $bits(pick_t);

  logic [SZ_W-1:0]   span [NREG];
  logic [ADDR_W-1:0] mask [NREG];
  logic [NREG-1:0]   hit;
  logic [NREG-1:0]   live;
  logic              tag_ign;
  pick_t             pick;
  logic [PICKW-1:0]  held;

  assign span[0] = in_span0;
  assign span[1] = in_span1;
  assign tag_ign = in_addr[SEL_BIT] ? in_tag_ign1 : in_tag_ign0;

  for (genvar r = 0; r < NREG; r++) begin : g_region
    assign live[r] = |span[r];

    rsel_span_mask #(.ADDR_W(ADDR_W), .SZ_W(SZ_W), .TAG_W(TAG_W)) u_mask (
      .span (span[r]),
      .ign  (tag_ign),
      .mask (mask[r])
    );

    rsel_region_hit #(.ADDR_W(ADDR_W), .WANT_ONES(r == 1)) u_hit (
      .addr (in_addr),
      .mask (mask[r]),
      .hit  (hit[r])
    );
  end

  rsel_arbiter u_arb (
    .live0 (live[0]),
    .live1 (live[1]),
    .hit0  (hit[0]),
    .hit1  (hit[1]),
    .off0  (in_off0),
    .off1  (in_off1),
    .pick  (pick)
  );

  rsel_out_reg #(.W(PICKW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (PICKW'(pick)),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (held)
  );

  assign {out_fault, out_sel1, out_sel0} = held;
endmodule

// File: rtl/rsel_checker.sv
module rsel_checker #(
  parameter int ADDR_W = 64,
  parameter int SZ_W   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [SZ_W-1:0]   in_span0,
  input logic [SZ_W-1:0]   in_span1,
  input logic              in_off0,
  input logic              in_off1,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_sel0,
  input logic              out_sel1,
  input logic              out_fault
);
  logic take;
  assign take = in_valid && in_ready;

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones({out_fault, out_sel1, out_sel0}) == 1)); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable({out_fault, out_sel1, out_sel0}))); // R11

  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R10

  AST_BOTH_OFF_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_off0 && in_off1) |=> out_fault); // R8

  AST_ZERO_SPANS_R0: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_span0 == '0 && in_span1 == '0 && !in_off0) |=> out_sel0); // R5
endmodule

bind xlat_region_sel rsel_checker #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_span0  (in_span0),
  .in_span1  (in_span1),
  .in_off0   (in_off0),
  .in_off1   (in_off1),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sel0  (out_sel0),
  .out_sel1  (out_sel1),
  .out_fault (out_fault)
);

// File: tb/tb_xlat_region_sel.sv
module tb_xlat_region_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_addr = '0;
  logic [5:0]  in_span0 = '0, in_span1 = '0;
  logic        in_tag_ign0 = 1'b0, in_tag_ign1 = 1'b0, in_off0 = 1'b0, in_off1 = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_sel0, out_sel1, out_fault;

  int checks = 0;
  int errors = 0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  xlat_region_sel dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_span0(in_span0), .in_span1(in_span1),
    .in_tag_ign0(in_tag_ign0), .in_tag_ign1(in_tag_ign1),
    .in_off0(in_off0), .in_off1(in_off1), .out_valid(out_valid),
    .out_ready(out_ready), .out_sel0(out_sel0), .out_sel1(out_sel1),
    .out_fault(out_fault)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // behavioural reference: returns {fault, r1, r0}
  function automatic logic [2:0] ref_pick(input logic [63:0] a, input int s0, input int s1,
                                          input bit t0, input bit t1, input bit d0, input bit d1);
    int  ign = ((a[55] ? t1 : t0) != 0) ? 8 : 0;
    bit  z0 = 1, o1 = 1;
    int  choice;
    for (int p = 64 - s0; p <= 63 - ign; p++) if (a[p]) z0 = 0;
    for (int p = 64 - s1; p <= 63 - ign; p++) if (!a[p]) o1 = 0;
    if (s0 != 0 && z0)      choice = 0;
    else if (s1 != 0 && o1) choice = 1;
    else if (s0 == 0)       choice = 0;
    else if (s1 == 0)       choice = 1;
    else                    choice = 2;
    if ((choice == 0 && d0) || (choice == 1 && d1)) choice = 2;
    return 3'b001 << choice;
  endfunction

  // one clock: check at falling edge, drive, update model at rising edge
  task automatic step(input bit iv, input logic [63:0] a, input int s0, input int s1,
                      input bit t0, input bit t1, input bit d0, input bit d1,
                      input bit ordy, input string tag);
    bit rdy_exp;
    chk("R10 out_valid", 64'(out_valid), 64'(exp_q.size() > 0));
    if (exp_q.size() > 0)
      chk(tag_q[0], 64'({out_fault, out_sel1, out_sel0}), 64'(exp_q[0]));
    in_valid = iv; in_addr = a; in_span0 = 6'(s0); in_span1 = 6'(s1);
    in_tag_ign0 = t0; in_tag_ign1 = t1; in_off0 = d0; in_off1 = d1; out_ready = ordy;
    rdy_exp = (exp_q.size() == 0) || ordy;
    #1;
    chk("R10 in_ready", 64'(in_ready), 64'(rdy_exp));
    @(posedge clk);
    if (exp_q.size() > 0 && ordy) begin
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
    if (iv && rdy_exp) begin
      exp_q.push_back(ref_pick(a, s0, s1, t0, t1, d0, d1));
      tag_q.push_back(tag);
    end
    @(negedge clk);
  endtask

  task automatic send(input logic [63:0] a, input int s0, input int s1,
                      input bit t0, input bit t1, input bit d0, input bit d1, input string tag);
    step(1, a, s0, s1, t0, t1, d0, d1, 1, tag);
  endtask

  task automatic idle(input bit ordy);
    step(0, '0, 0, 0, 0, 0, 0, 0, ordy, "idle");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int sizes[7] = '{0, 8, 16, 25, 39, 48, 63};
    logic [63:0] a;
    repeat (3) @(negedge clk);
    chk("R12 reset", 64'(out_valid), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 after release", 64'(out_valid), 64'(0));

    // R3 / R4 / R7
    send(64'h0000_1234_5678_9abc, 16, 16, 0, 0, 0, 0, "R3 low region");
    send(64'hFFFF_1234_5678_9abc, 16, 16, 0, 0, 0, 0, "R4 high region");
    send(64'h00F0_1234_5678_9abc, 16, 16, 0, 0, 0, 0, "R7 hole fault");
    // R1 / R2: bit55 = 0 uses enable 0
    send(64'hAB00_0000_1234_0000, 16, 16, 1, 0, 0, 0, "R2 tag ignored low");
    send(64'hAB00_0000_1234_0000, 16, 16, 0, 1, 0, 0, "R1 wrong enable low");
    // bit55 = 1 uses enable 1
    send(64'h12FF_FFFF_0000_0000, 16, 16, 0, 1, 0, 0, "R2 tag ignored high");
    send(64'h12FF_FFFF_0000_0000, 16, 16, 1, 0, 0, 0, "R1 wrong enable high");
    send(64'h7700_0000_0000_0000, 8, 16, 1, 0, 0, 0, "R2 empty range match");
    // R5 / R6 fallbacks
    send(64'h1234_0000_0000_0000, 0, 16, 0, 0, 0, 0, "R5 region0 fallback");
    send(64'hFFFF_0000_0000_0000, 0, 16, 0, 0, 0, 0, "R4 match beats R5 fallback");
    send(64'h8000_0000_0000_0000, 16, 0, 0, 0, 0, 0, "R6 region1 fallback");
    send(64'h0000_8000_0000_0000, 16, 0, 0, 0, 0, 0, "R3 match beats R6 fallback");
    send(64'h5555_0000_0000_0000, 0, 0, 0, 0, 0, 0, "R5 both sizes zero");
    // R8 disables
    send(64'h0000_0000_0000_0040, 16, 16, 0, 0, 1, 0, "R8 region0 disabled");
    send(64'h0000_0000_0000_0040, 16, 16, 0, 0, 0, 1, "R8 other region disabled");
    send(64'hFFFF_0000_0000_0040, 16, 16, 0, 0, 0, 1, "R8 region1 disabled");
    idle(1);

    // R11 stall: one accepted, a second offered while blocked
    step(1, 64'hFFFF_FFFF_0000_0000, 32, 32, 0, 0, 0, 0, 0, "R11 held result");
    step(1, 64'h0000_0000_0000_0000, 32, 32, 0, 0, 0, 0, 0, "R11 blocked");
    step(0, '0, 0, 0, 0, 0, 0, 0, 0, "idle");
    step(0, '0, 0, 0, 0, 0, 0, 0, 0, "idle");
    idle(1);
    idle(1);

    // R9 / R10 random traffic with back-pressure
    for (int n = 0; n < 400; n++) begin
      a = {$urandom, $urandom};
      case ($urandom_range(0, 3))
        0: a[63:40] = '0;
        1: a[63:40] = '1;
        2: a[55:40] = '0;
        default: ;
      endcase
      step($urandom_range(0, 3) != 0, a,
           sizes[$urandom_range(0, 6)], sizes[$urandom_range(0, 6)],
           1'($urandom), 1'($urandom), ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
           $urandom_range(0, 2) != 0, "R9 random outcome");
    end
    idle(1);
    idle(1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule